// File: doc/BRIEF.md
# Debug signal observation multiplexer

This block lets software pick which internal chip signals appear on eight debug output pins. Each pin has its own 16-way selector. A candidate bus carries sixteen inputs per pin, 128 in all, and a 4-bit select field per pin picks one of them. Select code 15 on pin p does not take a candidate input. It routes bit p of a software-owned general-purpose output (GPO) byte to the pin, so software can also drive the pins directly.

Software uses a plain 32-bit register bus. A bus write takes effect at the next rising clock edge. Read data is combinational from the address. There are separate write-one-to-set and write-one-to-clear locations for the GPO byte. A global enable is held in a two-state machine:
- `ST_OFF` moves to `ST_ON` on a control write whose bit 0 is 1.
- `ST_ON` moves back to `ST_OFF` on a control write whose bit 0 is 0.
- Every other cycle holds the current state.

While the block is in `ST_OFF`, all pins are low. Pins follow selection changes and candidate changes in the same cycle, with no register in the pin path.

Top module: `dbgmux_top`

## Requirements
- R1: After reset, the control word, the selector word and the GPO byte read as zero, and all eight pins are low.
- R2: Offset 0x000 holds a 32-bit control word that reads back exactly as last written. Bit 0 written as 1 enables the pins, and bit 0 written as 0 disables them, from the next clock edge.
- R3: Offset 0x004 holds the 32-bit selector word, which reads back exactly as last written. The select code for pin p sits in bits 4p+3 down to 4p.
- R4: While enabled, pin p with select code c below 15 shows candidate input bit 16p+c.
- R5: While enabled, pin p with select code 15 shows bit p of the GPO byte.
- R6: A write to offset 0x014 sets every GPO bit whose write-data bit (7:0) is 1 and leaves the other GPO bits unchanged. Offset 0x014 reads as zero.
- R7: A write to offset 0x018 clears every GPO bit whose write-data bit (7:0) is 1 and leaves the other GPO bits unchanged. Offset 0x018 reads as zero.
- R8: While disabled, all eight pins are low whatever the select codes, GPO byte and candidate inputs are.
- R9: Offset 0x010 returns the current pin levels in bits 7:0 and zeros above. Offset 0x01C returns the GPO byte in bits 7:0.
- R10: Offset 0x3F4 returns the major revision (default 2) in bits 7:4 and the minor revision (default 1) in bits 3:0, so the default value is 0x21.
- R11: Reads from any other offset return zero. Writes to unmapped offsets, and writes to 0x010, 0x01C and 0x3F4, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sig_in | input | 128 | Candidate signals, 16 per pin, pin p at bits 16p+15..16p |
| dbg_out | output | 8 | Debug output pins |

## Verification
Most internal faults reach the pins at once, because the pins are combinational from the stored state. A wrong enable state gives pins that are all low when they should be live, or live when they should be low, from the first cycle after the bad control write. A corrupted select field or GPO bit changes one pin straight away. It also shows in the 0x010 readback in the same cycle, and the word readbacks expose it on the next read. A decode slip shows up as a register that drifts after a write to a neighbouring or unmapped offset.

// File: rtl/dbgmux_pkg.sv
package dbgmux_pkg;
    localparam int OFS_W = 12;
    localparam logic [OFS_W-1:0] OFS_CTRL = 12'h000;
    localparam logic [OFS_W-1:0] OFS_SEL  = 12'h004;
    localparam logic [OFS_W-1:0] OFS_PINS = 12'h010;
    localparam logic [OFS_W-1:0] OFS_SET  = 12'h014;
    localparam logic [OFS_W-1:0] OFS_CLR  = 12'h018;
    localparam logic [OFS_W-1:0] OFS_GPO  = 12'h01C;
    localparam logic [OFS_W-1:0] OFS_REV  = 12'h3F4;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } gate_state_e;
endpackage

// File: rtl/dbgmux_ctrl.sv
module dbgmux_ctrl
    import dbgmux_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctrl,
    input  logic                wr_sel,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   ctrl_word,
    output logic [SEL_BITS-1:0] sel_word,
    output logic                gate_on
);
    gate_state_e state_q, state_d;
    logic [DATA_W-1:1] ctrl_hi_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (wr_ctrl && wdata[0])  state_d = ST_ON;
            ST_ON:  if (wr_ctrl && !wdata[0]) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        gate_on   = (state_q == ST_ON);
        ctrl_word = {ctrl_hi_q, gate_on};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_hi_q <= '0;
            sel_word  <= '0;
        end else begin
            if (wr_ctrl) ctrl_hi_q <= wdata[DATA_W-1:1];
            if (wr_sel)  sel_word  <= wdata[SEL_BITS-1:0];
        end
    end

    a_r2_enable_on: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[0]) |=> gate_on);
    a_r2_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[0]) |=> !gate_on);
    a_r3_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(sel_word));
endmodule

// File: rtl/dbgmux_gpo.sv
module dbgmux_gpo #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_stb,
    input  logic            clr_stb,
    input  logic [NPIN-1:0] mask,
    output logic [NPIN-1:0] gpo_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       gpo_q <= '0;
        else if (set_stb) gpo_q <= gpo_q | mask;
        else if (clr_stb) gpo_q <= gpo_q & ~mask;
    end

    a_r6_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((gpo_q & $past(mask)) == $past(mask)));
    a_r7_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((gpo_q & $past(mask)) == '0));
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(gpo_q));
endmodule

// File: rtl/dbgmux_lane.sv
module dbgmux_lane #(
    parameter int SEL_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  gate_on,
    input  logic [SEL_W-1:0]      sel,
    input  logic [(1<<SEL_W)-1:0] cand,
    input  logic                  gpo_bit,
    output logic                  pin
);
    localparam logic [SEL_W-1:0] GPO_CODE = '1;

    always_comb begin
        if (!gate_on)              pin = 1'b0;
        else if (sel == GPO_CODE)  pin = gpo_bit;
        else                       pin = cand[sel];
    end

    a_r5_gpo_route: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && sel == GPO_CODE) |-> (pin == gpo_bit));
endmodule

// File: rtl/dbgmux_top.sv
module dbgmux_top
    import dbgmux_pkg::*;
#(
    parameter int NPIN = 8,
    parameter int SEL_W = 4,
    parameter int DATA_W = 32,
    parameter logic [3:0] REV_MAJOR = 4'd2,
    parameter logic [3:0] REV_MINOR = 4'd1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [OFS_W-1:0]               bus_addr,
    input  logic                           bus_we,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [NPIN*(1<<SEL_W)-1:0]     sig_in,
    output logic [NPIN-1:0]                dbg_out
);
    localparam int LANE_IN = 1 << SEL_W;
    localparam int SEL_BITS = NPIN * SEL_W;

    logic              wr_ctrl, wr_sel, wr_set, wr_clr;
    logic [DATA_W-1:0] ctrl_word;
    logic [SEL_BITS-1:0] sel_word;
    logic [NPIN-1:0]   gpo_q;
    logic              gate_on;

    always_comb begin
        wr_ctrl = bus_we && (bus_addr == OFS_CTRL);
        wr_sel  = bus_we && (bus_addr == OFS_SEL);
        wr_set  = bus_we && (bus_addr == OFS_SET);
        wr_clr  = bus_we && (bus_addr == OFS_CLR);
    end

    dbgmux_ctrl #(.DATA_W(DATA_W), .SEL_BITS(SEL_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_sel(wr_sel),
        .wdata(bus_wdata), .ctrl_word(ctrl_word), .sel_word(sel_word),
        .gate_on(gate_on)
    );

    dbgmux_gpo #(.NPIN(NPIN)) u_gpo (
        .clk(clk), .rst_n(rst_n), .set_stb(wr_set), .clr_stb(wr_clr),
        .mask(bus_wdata[NPIN-1:0]), .gpo_q(gpo_q)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_lane
        dbgmux_lane #(.SEL_W(SEL_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .gate_on(gate_on),
            .sel(sel_word[p*SEL_W +: SEL_W]),
            .cand(sig_in[p*LANE_IN +: LANE_IN]),
            .gpo_bit(gpo_q[p]), .pin(dbg_out[p])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: bus_rdata = ctrl_word;
            OFS_SEL:  bus_rdata = DATA_W'(sel_word);
            OFS_PINS: bus_rdata = DATA_W'(dbg_out);
            OFS_GPO:  bus_rdata = DATA_W'(gpo_q);
            OFS_REV:  bus_rdata = DATA_W'({REV_MAJOR, REV_MINOR});
            default:  bus_rdata = '0;
        endcase
    end

    a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_on |-> (dbg_out == '0));
    a_r11_gpo_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != OFS_SET && bus_addr != OFS_CLR) |=> $stable(gpo_q));
    a_r11_ctrl_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != OFS_CTRL) |=> $stable(ctrl_word));
endmodule

// File: tb/tb_dbgmux_top.sv
module tb_dbgmux_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] sig_in = '0;
    logic [7:0]   dbg_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dbgmux_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sig_in(sig_in),
        .dbg_out(dbg_out)
    );

    // {selector word, candidate seed, gpo byte}
    localparam logic [71:0] VEC [6] = '{
        {32'h7654_3210, 32'h8421_F00F, 8'h00},
        {32'hFFFF_FFFF, 32'h0000_0000, 8'hA5},
        {32'hF0F0_F0F0, 32'hFFFF_0001, 8'h3C},
        {32'hEDCB_A987, 32'h1234_5678, 8'hFF},
        {32'h0123_4567, 32'hDEAD_BEEF, 8'h81},
        {32'h9F3E_5F1F, 32'h7E81_C3A5, 8'h5A}
    };

    function automatic logic [7:0] exp_pins(input logic [31:0] m,
                                            input logic [127:0] s,
                                            input logic [7:0] g);
        logic [7:0] e;
        for (int p = 0; p < 8; p++) begin
            logic [3:0] c;
            c = m[4*p +: 4];
            e[p] = (c == 4'hF) ? g[p] : s[16*p + c];
        end
        return e;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h000, d); check("R1 ctrl", d, 32'h0);
        rd(12'h004, d); check("R1 sel", d, 32'h0);
        rd(12'h01C, d); check("R1 gpo", d, 32'h0);
        #1; check("R1 pins", {24'h0, dbg_out}, 32'h0);

        // R10 revision
        rd(12'h3F4, d); check("R10 rev", d, 32'h21);

        // R2 control readback and enable
        wr(12'h000, 32'hA5A5_5A5B);
        rd(12'h000, d); check("R2 ctrl readback", d, 32'hA5A5_5A5B);

        // R4 R5 R9 vector table
        for (int i = 0; i < 6; i++) begin
            logic [31:0] m, s;
            logic [7:0]  g, e;
            {m, s, g} = VEC[i];
            wr(12'h018, 32'hFF);
            wr(12'h014, {24'h0, g});
            wr(12'h004, m);
            sig_in = {4{s}};
            e = exp_pins(m, {4{s}}, g);
            #1;
            check("R4/R5 pins", {24'h0, dbg_out}, {24'h0, e});
            rd(12'h010, d); check("R9 pin readback", d, {24'h0, e});
            rd(12'h004, d); check("R3 sel readback", d, m);
        end

        // R3 field position: pin 3 only selects code 9
        sig_in = '0; sig_in[16*3 + 9] = 1'b1;
        wr(12'h004, 32'h0000_9000);
        #1; check("R3 field of pin 3", {24'h0, dbg_out}, 32'h08);

        // R6 / R7 set and clear
        wr(12'h018, 32'hFF);
        wr(12'h014, 32'h0000_0011);
        wr(12'h014, 32'h0000_0100);
        rd(12'h01C, d); check("R6 set keeps others", d, 32'h11);
        rd(12'h014, d); check("R6 set reads zero", d, 32'h0);
        wr(12'h014, 32'h0000_00C0);
        wr(12'h018, 32'h0000_0041);
        rd(12'h01C, d); check("R7 clear keeps others", d, 32'h90);
        rd(12'h018, d); check("R7 clear reads zero", d, 32'h0);

        // R8 disabled gates everything
        wr(12'h014, 32'hFF);
        wr(12'h004, 32'hFFFF_FFFF);
        sig_in = '1;
        #1; check("R8 enabled reference", {24'h0, dbg_out}, 32'hFF);
        wr(12'h000, 32'hFFFF_FFFE);
        #1; check("R8 pins low", {24'h0, dbg_out}, 32'h0);
        rd(12'h010, d); check("R9 pin readback disabled", d, 32'h0);
        rd(12'h000, d); check("R2 ctrl readback disabled", d, 32'hFFFF_FFFE);
        wr(12'h000, 32'h1);
        #1; check("R2 re-enable", {24'h0, dbg_out}, 32'hFF);

        // R11 unmapped and read-only locations
        wr(12'h008, 32'h0);
        wr(12'h01C, 32'h0);
        wr(12'h010, 32'h0);
        wr(12'h3F4, 32'h0);
        wr(12'h020, 32'h0);
        rd(12'h000, d); check("R11 ctrl untouched", d, 32'h1);
        rd(12'h004, d); check("R11 sel untouched", d, 32'hFFFF_FFFF);
        rd(12'h01C, d); check("R11 gpo untouched", d, 32'hFF);
        rd(12'h3F4, d); check("R11 rev untouched", d, 32'h21);
        rd(12'h008, d); check("R11 unmapped 008", d, 32'h0);
        rd(12'h3F8, d); check("R11 unmapped 3F8", d, 32'h0);
        rd(12'h005, d); check("R11 unaligned 005", d, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule